// File: doc/BRIEF.md
# Latched Down-Counting Interval Timer

This block is a 16-bit interval timer. A host writes a reload value one byte at a time through a small byte-wide register port. Once started, the counter moves down by one on every clock. When it underflows it reloads from the stored value and sets an interrupt status flag. The flag reaches the interrupt pin only while the mask bit is set.

The timer has two modes. In continuous mode it reloads and keeps counting. In one-shot mode it reloads once and then stops. Continuous reload follows a fixed pattern: the counter never reads as zero, the reloaded value is visible for two consecutive cycles, and so each period lasts the reload value plus one cycle. A build-time parameter moves the interrupt pin one cycle later without changing the count sequence. This lets software written for either timing variant be matched cycle for cycle.

The host reads the live counter bytes, reads and writes the control and mask registers, and clears the status flag by reading it. All register access is synchronous and takes effect at the clock edge that ends the access cycle.

Top module: `ivl_timer`

## Requirements
- R1: A synchronous active-high reset sets the reload value and the counter to 16'hFFFF and clears control, status and mask. Every register then reads back its reset value.
- R2: In continuous mode, a cycle that shows a counter value of 1 is the underflow cycle. The next cycle shows the reload value, and the cycle after that shows it again. Counting then resumes. With a reload of 5, per-cycle reads give 5,4,3,2,1,5,5,4,3,2,1,5,5 and never 0.
- R3: One continuous period lasts reload+1 cycles. A reload of 2 gives the sequence 2,1,2,2,1,2,2.
- R4: In one-shot mode (control bit 1 set together with run bit 0), an underflow reloads the counter, clears the run bit and stops counting. The status flag is set only once.
- R5: Writing the reload high byte (address 1) while stopped also loads the whole counter from the new reload value. Writing the reload low byte (address 0) never loads the counter. Writing the high byte while running does not load it.
- R6: Writing control (address 2) with bit 2 set copies the reload value into the counter at that clock edge, whether or not the timer is running. Bit 2 always reads back as 0.
- R7: Status bit 0 (address 3) is set in the cycle after an underflow. A read of address 3 clears it, but an underflow in the same cycle wins over the clear.
- R8: With IRQ_DELAY=0, the interrupt output is the status flag ANDed with mask bit 0 (address 4). While the mask is 0 the flag still sets but the output stays low.
- R9: IRQ_DELAY=1 makes the interrupt output rise and fall exactly one cycle later than with IRQ_DELAY=0, and leaves counting unchanged.
- R10: Register map. Address 0 reads the live counter low byte and writes the reload low byte. Address 1 does the same for the high bytes. Address 2 is control: bit 0 run, bit 1 one-shot, bit 2 force load. Counter reads return the value present in the access cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock; the counter steps once per cycle |
| rst_i | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Register access strobe for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, valid in the cycle of a read access |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The properties assume one register access per cycle, with strobe, direction, address and data held steady for the whole cycle. They also assume the reload value is non-zero whenever the never-zero property is expected to hold, since a zero reload is the one case where the counter can legitimately show 0. The stimulus only loads reload values of 2, 5 and 9, and drives every bus field once per cycle just after the clock edge. Two copies of the block run side by side, one per interrupt-delay setting, so the one-cycle offset is compared on identical traffic.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    localparam int DATA_W = 8;
    localparam int CNT_W  = 2 * DATA_W;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd1;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd2;
    localparam logic [ADDR_W-1:0] A_STAT   = 3'd3;
    localparam logic [ADDR_W-1:0] A_MASK   = 3'd4;

    localparam int CTRL_RUN     = 0;
    localparam int CTRL_ONESHOT = 1;
    localparam int CTRL_FORCE   = 2;

    localparam logic [CNT_W-1:0] CNT_RESET = '1;

    typedef struct packed {
        logic [CNT_W-1:0] reload;
        logic             run;
        logic             oneshot;
        logic             mask;
    } regs_t;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             hold;
    } core_t;

    typedef struct packed {
        logic flag;
    } irqst_t;

endpackage

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
    import ivl_timer_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              oneshot_stop_i,
    output logic [CNT_W-1:0]  reload_q_o,
    output logic [CNT_W-1:0]  reload_d_o,
    output logic              run_q_o,
    output logic              oneshot_q_o,
    output logic              mask_q_o,
    output logic              load_now_o,
    output logic              force_ld_o,
    output logic              stat_rd_o
);

    regs_t r_d, r_q;
    logic  wr;

    always_comb begin
        r_d = r_q;
        wr  = cs_i && we_i;

        if (wr && addr_i == A_CNT_LO) begin
            r_d.reload[DATA_W-1:0] = wdata_i;
        end
        if (wr && addr_i == A_CNT_HI) begin
            r_d.reload[CNT_W-1:DATA_W] = wdata_i;
        end

        // a one-shot expiry stops the timer unless the host rewrites control now
        if (oneshot_stop_i) begin
            r_d.run = 1'b0;
        end
        if (wr && addr_i == A_CTRL) begin
            r_d.run     = wdata_i[CTRL_RUN];
            r_d.oneshot = wdata_i[CTRL_ONESHOT];
        end

        if (wr && addr_i == A_MASK) begin
            r_d.mask = wdata_i[0];
        end

        load_now_o = wr && (addr_i == A_CNT_HI) && !r_q.run;
        force_ld_o = wr && (addr_i == A_CTRL) && wdata_i[CTRL_FORCE];
        stat_rd_o  = cs_i && !we_i && (addr_i == A_STAT);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            r_q.reload  <= CNT_RESET;
            r_q.run     <= 1'b0;
            r_q.oneshot <= 1'b0;
            r_q.mask    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign reload_q_o  = r_q.reload;
    assign reload_d_o  = r_d.reload;
    assign run_q_o     = r_q.run;
    assign oneshot_q_o = r_q.oneshot;
    assign mask_q_o    = r_q.mask;

endmodule

// File: rtl/ivl_timer_core.sv
module ivl_timer_core
    import ivl_timer_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             run_i,
    input  logic             oneshot_i,
    input  logic [CNT_W-1:0] reload_q_i,
    input  logic [CNT_W-1:0] reload_d_i,
    input  logic             load_now_i,
    input  logic             force_ld_i,
    output logic [CNT_W-1:0] cnt_q_o,
    output logic             underflow_o,
    output logic             oneshot_stop_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    core_t c_d, c_q;

    always_comb begin
        c_d = c_q;

        // the cycle that shows 1 (or 0 for a zero reload) is the expiry cycle
        underflow_o    = run_i && !c_q.hold && (c_q.cnt <= ONE);
        oneshot_stop_o = underflow_o && oneshot_i;

        if (run_i) begin
            if (c_q.hold) begin
                c_d.hold = 1'b0;
            end else if (underflow_o) begin
                c_d.cnt  = reload_q_i;
                c_d.hold = !oneshot_i;
            end else begin
                c_d.cnt = c_q.cnt - ONE;
            end
        end

        if (force_ld_i) begin
            c_d.cnt  = reload_q_i;
            c_d.hold = 1'b0;
        end
        if (load_now_i) begin
            c_d.cnt  = reload_d_i;
            c_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            c_q.cnt  <= CNT_RESET;
            c_q.hold <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign cnt_q_o = c_q.cnt;

endmodule

// File: rtl/ivl_timer_irq.sv
module ivl_timer_irq #(
    parameter int IRQ_DELAY = 0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic underflow_i,
    input  logic stat_rd_i,
    input  logic mask_i,
    output logic flag_q_o,
    output logic irq_o
);
    import ivl_timer_pkg::*;

    irqst_t s_d, s_q;
    logic   raw_irq;

    always_comb begin
        s_d = s_q;
        if (underflow_i) begin
            s_d.flag = 1'b1;
        end else if (stat_rd_i) begin
            s_d.flag = 1'b0;
        end
        raw_irq = s_q.flag && mask_i;
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            s_q.flag <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    generate
        if (IRQ_DELAY == 0) begin : g_direct
            assign irq_o = raw_irq;
        end else begin : g_late
            logic late_d, late_q;
            always_comb late_d = raw_irq;
            always_ff @(posedge clk_i) begin
                if (rst_i) late_q <= 1'b0;
                else       late_q <= late_d;
            end
            assign irq_o = late_q;
        end
    endgenerate

    assign flag_q_o = s_q.flag;

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int IRQ_DELAY = 0
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              cs_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    logic [CNT_W-1:0] reload_q, reload_d, cnt_q;
    logic run_q, oneshot_q, mask_q;
    logic load_now, force_ld, stat_rd;
    logic underflow, os_stop, flag_q;

    ivl_timer_regs u_regs (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .cs_i           (cs_i),
        .we_i           (we_i),
        .addr_i         (addr_i),
        .wdata_i        (wdata_i),
        .oneshot_stop_i (os_stop),
        .reload_q_o     (reload_q),
        .reload_d_o     (reload_d),
        .run_q_o        (run_q),
        .oneshot_q_o    (oneshot_q),
        .mask_q_o       (mask_q),
        .load_now_o     (load_now),
        .force_ld_o     (force_ld),
        .stat_rd_o      (stat_rd)
    );

    ivl_timer_core u_core (
        .clk_i          (clk_i),
        .rst_i          (rst_i),
        .run_i          (run_q),
        .oneshot_i      (oneshot_q),
        .reload_q_i     (reload_q),
        .reload_d_i     (reload_d),
        .load_now_i     (load_now),
        .force_ld_i     (force_ld),
        .cnt_q_o        (cnt_q),
        .underflow_o    (underflow),
        .oneshot_stop_o (os_stop)
    );

    ivl_timer_irq #(.IRQ_DELAY(IRQ_DELAY)) u_irq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .underflow_i (underflow),
        .stat_rd_i   (stat_rd),
        .mask_i      (mask_q),
        .flag_q_o    (flag_q),
        .irq_o       (irq_o)
    );

    always_comb begin
        rdata_o = '0;
        if (cs_i && !we_i) begin
            case (addr_i)
                A_CNT_LO: rdata_o = cnt_q[DATA_W-1:0];
                A_CNT_HI: rdata_o = cnt_q[CNT_W-1:DATA_W];
                A_CTRL: begin
                    rdata_o[CTRL_RUN]     = run_q;
                    rdata_o[CTRL_ONESHOT] = oneshot_q;
                end
                A_STAT:  rdata_o[0] = flag_q;
                A_MASK:  rdata_o[0] = mask_q;
                default: rdata_o = '0;
            endcase
        end
    end

endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk
    import ivl_timer_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [CNT_W-1:0]  reload,
    input logic [CNT_W-1:0]  cnt,
    input logic              run,
    input logic              oneshot,
    input logic              mask,
    input logic              underflow,
    input logic              force_ld,
    input logic              stat_rd,
    input logic              flag,
    input logic              irq
);

    // R2
    reload_value_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> (cnt == $past(reload)));

    // R2
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !oneshot && cnt != '0 && reload != '0) |=> (cnt != '0));

    // R4
    oneshot_halt_chk: assert property (@(posedge clk) disable iff (rst)
        (underflow && oneshot && !(cs && we && addr == A_CTRL)) |=> !run);

    // R6
    force_copy_chk: assert property (@(posedge clk) disable iff (rst)
        force_ld |=> (cnt == $past(reload)));

    // R7
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        underflow |=> flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !underflow) |=> !flag);

    // R8
    mask_block_chk: assert property (@(posedge clk) disable iff (rst)
        (!mask && !$past(mask)) |-> !irq);

endmodule

bind ivl_timer ivl_timer_chk u_chk (
    .clk       (clk_i),
    .rst       (rst_i),
    .cs        (cs_i),
    .we        (we_i),
    .addr      (addr_i),
    .reload    (reload_q),
    .cnt       (cnt_q),
    .run       (run_q),
    .oneshot   (oneshot_q),
    .mask      (mask_q),
    .underflow (underflow),
    .force_ld  (force_ld),
    .stat_rd   (stat_rd),
    .flag      (flag_q),
    .irq       (irq_o)
);

// File: tb/sim_ivl_timer.sv
`timescale 1ns/1ps
module sim_ivl_timer;

    typedef struct {
        bit         chk_rd;
        logic [7:0] rd;
        bit         chk_irq;
        bit         i0;
        bit         i1;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, we = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata0, rdata1;
    logic       irq0, irq1;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    item_t q[$];

    always #10 clk = ~clk;

    ivl_timer #(.IRQ_DELAY(0)) u0 (
        .clk_i(clk), .rst_i(rst), .cs_i(cs), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata0), .irq_o(irq0));

    ivl_timer #(.IRQ_DELAY(1)) u1 (
        .clk_i(clk), .rst_i(rst), .cs_i(cs), .we_i(we), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata1), .irq_o(irq1));

    // driver: one bus cycle plus the result expected in that cycle
    task automatic step(input logic c, input logic w, input logic [2:0] a,
                        input logic [7:0] d, input bit crd, input logic [7:0] erd,
                        input bit cirq, input bit e0, input bit e1, input string tag);
        item_t it;
        @(posedge clk);
        #1;
        cs = c; we = w; addr = a; wdata = d;
        it.chk_rd = crd; it.rd = erd; it.chk_irq = cirq;
        it.i0 = e0; it.i1 = e1; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        step(1'b1, 1'b1, a, d, 0, 8'h00, 0, 0, 0, "");
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
        step(1'b1, 1'b0, a, 8'h00, 1, e, 0, 0, 0, tag);
    endtask

    task automatic rdi(input logic [2:0] a, input logic [7:0] e,
                       input bit e0, input bit e1, input string tag);
        step(1'b1, 1'b0, a, 8'h00, 1, e, 1, e0, e1, tag);
    endtask

    // monitor: compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.chk_rd) begin
                checks++;
                if (rdata0 !== it.rd) begin
                    fails++;
                    $display("FAIL %s rdata actual=%h expected=%h", it.tag, rdata0, it.rd);
                end
            end
            if (it.chk_irq) begin
                checks++;
                if (irq0 !== it.i0 || irq1 !== it.i1) begin
                    fails++;
                    $display("FAIL %s irq actual=%b/%b expected=%b/%b",
                             it.tag, irq0, irq1, it.i0, it.i1);
                end
            end
        end
    end

    initial begin
        #(20 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] seq5 [13] = '{8'd5, 8'd4, 8'd3, 8'd2, 8'd1, 8'd5, 8'd5,
                                  8'd4, 8'd3, 8'd2, 8'd1, 8'd5, 8'd5};
        logic [7:0] seq2 [7]  = '{8'd2, 8'd1, 8'd2, 8'd2, 8'd1, 8'd2, 8'd2};
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset state
        rd(3'd0, 8'hFF, "R1 cnt lo");
        rd(3'd1, 8'hFF, "R1 cnt hi");
        rdi(3'd2, 8'h00, 0, 0, "R1 ctrl");
        rd(3'd3, 8'h00, "R1 status");
        rd(3'd4, 8'h00, "R1 mask");

        // R5 low byte never loads, high byte loads while stopped
        wr(3'd0, 8'd5);
        rd(3'd0, 8'hFF, "R5 lo write no load");
        wr(3'd1, 8'd0);
        rd(3'd0, 8'd5, "R5 hi write load lo");
        rd(3'd1, 8'd0, "R5 hi write load hi");

        // R2 R3 R9 continuous sequence with reload 5
        wr(3'd4, 8'd1);
        wr(3'd2, 8'h01);
        for (int i = 0; i < 13; i++)
            rdi(3'd0, seq5[i], (i >= 5), (i >= 6), "R2 R3 R9 R10 sequence");
        wr(3'd2, 8'h00);

        // R7 read clears, R9 late edge on the falling side
        rdi(3'd3, 8'h01, 1, 1, "R7 status set");
        rdi(3'd3, 8'h00, 0, 1, "R7 R9 status cleared");
        rdi(3'd0, 8'd3, 0, 0, "R9 stopped count");

        // R6 force load while stopped
        wr(3'd0, 8'd2);
        rd(3'd0, 8'd3, "R5 lo write no load");
        wr(3'd2, 8'h04);
        rd(3'd0, 8'd2, "R6 force stopped");
        rd(3'd2, 8'h00, "R6 force bit reads 0");

        // R4 one-shot
        wr(3'd2, 8'h03);
        rdi(3'd0, 8'd2, 0, 0, "R4 first");
        rdi(3'd0, 8'd1, 0, 0, "R4 expiry");
        rdi(3'd0, 8'd2, 1, 0, "R4 reloaded");
        rdi(3'd0, 8'd2, 1, 1, "R4 stopped");
        rd(3'd2, 8'h02, "R4 run cleared");
        rd(3'd3, 8'h01, "R4 flag");
        rd(3'd3, 8'h00, "R4 single flag");

        // R3 R8 reload 2 with mask off
        wr(3'd4, 8'd0);
        wr(3'd2, 8'h01);
        for (int i = 0; i < 7; i++)
            rdi(3'd0, seq2[i], 0, 0, "R3 R8 period");
        wr(3'd2, 8'h00);
        rdi(3'd3, 8'h01, 0, 0, "R8 flag without irq");
        rd(3'd3, 8'h00, "R7 cleared");

        // R6 force while running, R5 hi write while running
        wr(3'd0, 8'd9);
        wr(3'd2, 8'h01);
        wr(3'd2, 8'h05);
        rd(3'd0, 8'd9, "R6 force running");
        rd(3'd0, 8'd8, "R6 after force");
        rd(3'd0, 8'd7, "R6 after force");
        wr(3'd1, 8'd0);
        rd(3'd0, 8'd5, "R5 hi write running no load");
        wr(3'd2, 8'h00);
        step(1'b0, 1'b0, 3'd0, 8'h00, 0, 8'h00, 0, 0, 0, "");

        repeat (3) @(posedge clk);
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule